// File: doc/BRIEF.md
# Peripheral Clock-Stop and Reset Control Bank

This block is a small register bank that a processor uses to hold peripherals in reset and to stop or run their clocks. It holds one reset bit and one clock-stop bit for each of 64 peripheral slots, packed into 32-bit words. Software never does a read-modify-write. Each word has a set address and a clear alias one word above it. Writing a mask to the set address raises the masked bits. Writing a mask to the clear alias lowers them. All other bits keep their value.

The bank drives one reset line and one clock-enable line per slot. It also drives a per-slot "on" status. A slot counts as on only when its clock runs and, if the slot is tied to a reset bit, that reset bit is released. The clock gating cells are not part of this block; they take the clock-enable outputs. One clock bit (slot 14 by default) has the inverted sense, so a 1 there runs the clock.

Top module: `clkrst_bank`

## Requirements
- R1: After the asynchronous active-low reset, every reset bit is 1 and every clock is stopped. So `rst_out` is all ones, `clk_en` and `slot_on` are all zeros, reset words read 0xFFFFFFFF, clock word 0 reads 0xFFFFBFFF and clock word 1 reads 0xFFFFFFFF.
- R2: Reset words sit at 0x040 (slots 0–31) and 0x050 (slots 32–63). Clock-stop words sit at 0x080 (slots 0–31) and 0x090 (slots 32–63). Slot s uses bit s mod 32 of its word.
- R3: A write to a word's set address ORs the write mask into that word. Bits that are zero in the mask keep their value.
- R4: A write to a word's clear alias (set address + 4) clears the masked bits. Bits that are zero in the mask keep their value.
- R5: A read of the set address or of the clear alias returns the word's current value on `rdata` in the same cycle. A read changes no state.
- R6: `rst_out[s]` equals reset bit s. A value of 1 holds the peripheral in reset.
- R7: For every slot except 14, `clk_en[s]` is the inverse of clock-stop bit s. For slot 14, `clk_en[14]` equals the bit.
- R8: `slot_on[s]` is `clk_en[s]` AND NOT the reset bit linked to slot s. By default slot s links to reset bit s, except slots 0 and 34, which have no link and report `clk_en` alone.
- R9: A write to an address outside the eight mapped addresses changes no state. A read of such an address returns 0.
- R10: State changes only on a clock edge where `sel` and `wr` are both 1. While `sel` is 0, or during a read, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus access strobe |
| wr | input | 1 | 1 = write, 0 = read (qualified by `sel`) |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write mask |
| rdata | output | 32 | Read data, combinational; zero when not reading a mapped word |
| rst_out | output | 64 | Per-slot reset lines, 1 = held in reset |
| clk_en | output | 64 | Per-slot clock enable for the gating cells |
| slot_on | output | 64 | Per-slot enabled status, masked by the linked reset |

## Verification
Some properties are checked on every cycle:
- After a set or clear write to reset word 0, the masked reset lines take their new value.
- After a set write to clock word 0, the masked clocks report stopped in each bit's own sense.
- No output moves without a write strobe.
- No slot reports on while its clock is stopped or its linked reset is held.

The directed scenarios cover the rest: the reset image, the read-back through both aliases, the upper words, the unlinked slots, the inverted bit 14 in both directions, and accesses that miss every mapped address.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

   // upper limit of slots handled by the link table encoding
   localparam int MAX_SLOTS = 64;
   // bits per entry of the slot-to-reset link table
   localparam int LINK_FW   = 8;

   typedef enum logic {
      BANK_RST = 1'b0,
      BANK_CLK = 1'b1
   } bank_e;

   // default link table: slot s uses reset bit s
   function automatic logic [MAX_SLOTS*LINK_FW-1:0] identity_links();
      logic [MAX_SLOTS*LINK_FW-1:0] t;
      t = '0;
      for (int s = 0; s < MAX_SLOTS; s++) begin
         t[s*LINK_FW +: LINK_FW] = LINK_FW'(s);
      end
      return t;
   endfunction

endpackage

// File: rtl/clkrst_decode.sv
module clkrst_decode #(
   parameter int ADDR_W      = 12,
   parameter int NUM_WORDS   = 2,
   parameter int RST_BASE    = 'h040,
   parameter int CLK_BASE    = 'h080,
   parameter int WORD_STRIDE = 'h010,
   localparam int WIDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output clkrst_pkg::bank_e bank,
   output logic              is_clr,
   output logic [WIDX_W-1:0] word_idx
);
   import clkrst_pkg::*;

   always_comb begin
      hit      = 1'b0;
      bank     = BANK_RST;
      is_clr   = 1'b0;
      word_idx = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (addr == ADDR_W'(RST_BASE + w*WORD_STRIDE)) begin
            hit = 1'b1; bank = BANK_RST; is_clr = 1'b0; word_idx = WIDX_W'(w);
         end
         if (addr == ADDR_W'(RST_BASE + w*WORD_STRIDE + 4)) begin
            hit = 1'b1; bank = BANK_RST; is_clr = 1'b1; word_idx = WIDX_W'(w);
         end
         if (addr == ADDR_W'(CLK_BASE + w*WORD_STRIDE)) begin
            hit = 1'b1; bank = BANK_CLK; is_clr = 1'b0; word_idx = WIDX_W'(w);
         end
         if (addr == ADDR_W'(CLK_BASE + w*WORD_STRIDE + 4)) begin
            hit = 1'b1; bank = BANK_CLK; is_clr = 1'b1; word_idx = WIDX_W'(w);
         end
      end
   end

endmodule

// File: rtl/clkrst_word.sv
module clkrst_word #(
   parameter int               DATA_W    = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RESET_VAL;
      end else if (set_en) begin
         q <= q | mask;
      end else if (clr_en) begin
         q <= q & ~mask;
      end
   end

endmodule

// File: rtl/clkrst_status.sv
module clkrst_status #(
   parameter int NUM_SLOTS = 64,
   parameter logic [NUM_SLOTS-1:0] INV_CLK_MASK = '0,
   parameter logic [NUM_SLOTS-1:0] RST_LINK_MASK = '1,
   parameter logic [clkrst_pkg::MAX_SLOTS*clkrst_pkg::LINK_FW-1:0] RST_LINK_IDX =
      clkrst_pkg::identity_links()
) (
   input  logic [NUM_SLOTS-1:0] stop_bits,
   input  logic [NUM_SLOTS-1:0] rst_bits,
   output logic [NUM_SLOTS-1:0] clk_en,
   output logic [NUM_SLOTS-1:0] slot_on
);
   import clkrst_pkg::*;

   // unlinked slots leave some reset bits unread here
   logic unused_rst;
   assign unused_rst = ^rst_bits;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int LI = int'(RST_LINK_IDX[s*LINK_FW +: LINK_FW]);

      if (INV_CLK_MASK[s]) begin : g_inv
         assign clk_en[s] = stop_bits[s];
      end else begin : g_norm
         assign clk_en[s] = ~stop_bits[s];
      end

      if (RST_LINK_MASK[s]) begin : g_link
         if (LI >= NUM_SLOTS) begin : g_bad_link
            $error("reset link index out of range");
         end
         assign slot_on[s] = clk_en[s] & ~rst_bits[LI];
      end else begin : g_free
         assign slot_on[s] = clk_en[s];
      end
   end

endmodule

// File: rtl/clkrst_bank.sv
module clkrst_bank #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int NUM_SLOTS   = 64,
   parameter int RST_BASE    = 'h040,
   parameter int CLK_BASE    = 'h080,
   parameter int WORD_STRIDE = 'h010,
   parameter logic [NUM_SLOTS-1:0] INV_CLK_MASK  = NUM_SLOTS'(64'h0000_0000_0000_4000),
   parameter logic [NUM_SLOTS-1:0] RST_LINK_MASK = NUM_SLOTS'(64'hFFFF_FFFB_FFFF_FFFE),
   parameter logic [clkrst_pkg::MAX_SLOTS*clkrst_pkg::LINK_FW-1:0] RST_LINK_IDX =
      clkrst_pkg::identity_links()
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic [NUM_SLOTS-1:0] rst_out,
   output logic [NUM_SLOTS-1:0] clk_en,
   output logic [NUM_SLOTS-1:0] slot_on
);
   import clkrst_pkg::*;

   localparam int NUM_WORDS = NUM_SLOTS / DATA_W;
   localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam logic [NUM_SLOTS-1:0] CLK_RESET_IMG = ~INV_CLK_MASK;

   if (NUM_SLOTS % DATA_W != 0) begin : g_bad_split
      $error("slot count must be a multiple of the word width");
   end
   if (NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("slot count exceeds link table capacity");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("clear alias at +4 requires 32-bit words");
   end
   if (WORD_STRIDE < 8) begin : g_bad_stride
      $error("word stride must leave room for the clear alias");
   end

   logic              hit;
   bank_e             bank;
   logic              is_clr;
   logic [WIDX_W-1:0] word_idx;
   logic              wr_go;

   clkrst_decode #(
      .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .RST_BASE(RST_BASE),
      .CLK_BASE(CLK_BASE), .WORD_STRIDE(WORD_STRIDE)
   ) u_dec (
      .addr(addr), .hit(hit), .bank(bank), .is_clr(is_clr), .word_idx(word_idx)
   );

   assign wr_go = sel & wr & hit;

   logic [DATA_W-1:0] rst_word [NUM_WORDS];
   logic [DATA_W-1:0] clk_word [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic sel_w;
      assign sel_w = wr_go && (word_idx == WIDX_W'(w));

      clkrst_word #(.DATA_W(DATA_W), .RESET_VAL('1)) u_rst (
         .clk(clk), .rst_n(rst_n),
         .set_en(sel_w && bank == BANK_RST && !is_clr),
         .clr_en(sel_w && bank == BANK_RST &&  is_clr),
         .mask(wdata), .q(rst_word[w])
      );

      clkrst_word #(.DATA_W(DATA_W), .RESET_VAL(CLK_RESET_IMG[w*DATA_W +: DATA_W])) u_clk (
         .clk(clk), .rst_n(rst_n),
         .set_en(sel_w && bank == BANK_CLK && !is_clr),
         .clr_en(sel_w && bank == BANK_CLK &&  is_clr),
         .mask(wdata), .q(clk_word[w])
      );

      assign rst_out[w*DATA_W +: DATA_W] = rst_word[w];
   end

   logic [NUM_SLOTS-1:0] stop_bits;
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_flat
      assign stop_bits[w*DATA_W +: DATA_W] = clk_word[w];
   end

   always_comb begin
      rdata = '0;
      if (sel && !wr && hit) begin
         rdata = (bank == BANK_CLK) ? clk_word[word_idx] : rst_word[word_idx];
      end
   end

   clkrst_status #(
      .NUM_SLOTS(NUM_SLOTS), .INV_CLK_MASK(INV_CLK_MASK),
      .RST_LINK_MASK(RST_LINK_MASK), .RST_LINK_IDX(RST_LINK_IDX)
   ) u_stat (
      .stop_bits(stop_bits), .rst_bits(rst_out), .clk_en(clk_en), .slot_on(slot_on)
   );

endmodule

// File: rtl/clkrst_bank_chk.sv
module clkrst_bank_chk #(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NUM_SLOTS = 64,
   parameter int RST_BASE  = 'h040,
   parameter int CLK_BASE  = 'h080,
   parameter logic [NUM_SLOTS-1:0] INV_CLK_MASK  = '0,
   parameter logic [NUM_SLOTS-1:0] RST_LINK_MASK = '1,
   parameter logic [clkrst_pkg::MAX_SLOTS*clkrst_pkg::LINK_FW-1:0] RST_LINK_IDX =
      clkrst_pkg::identity_links()
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sel,
   input logic                 wr,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wdata,
   input logic [NUM_SLOTS-1:0] rst_out,
   input logic [NUM_SLOTS-1:0] clk_en,
   input logic [NUM_SLOTS-1:0] slot_on
);
   import clkrst_pkg::*;

   // R3
   rst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && addr == ADDR_W'(RST_BASE)) |=>
      ((rst_out[DATA_W-1:0] & $past(wdata)) == $past(wdata)));

   // R4
   rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && addr == ADDR_W'(RST_BASE + 4)) |=>
      ((rst_out[DATA_W-1:0] & $past(wdata)) == '0));

   // R7
   clk_stop_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && addr == ADDR_W'(CLK_BASE)) |=>
      (((clk_en[DATA_W-1:0] ^ INV_CLK_MASK[DATA_W-1:0]) & $past(wdata)) == '0));

   // R10
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && wr) |=> ($stable(rst_out) && $stable(clk_en) && $stable(slot_on)));

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_on
      localparam int LI = int'(RST_LINK_IDX[s*LINK_FW +: LINK_FW]);
      // R8
      slot_on_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         slot_on[s] |-> (clk_en[s] && !(RST_LINK_MASK[s] && rst_out[LI])));
   end

endmodule

bind clkrst_bank clkrst_bank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS),
   .RST_BASE(RST_BASE), .CLK_BASE(CLK_BASE),
   .INV_CLK_MASK(INV_CLK_MASK), .RST_LINK_MASK(RST_LINK_MASK),
   .RST_LINK_IDX(RST_LINK_IDX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
   .rst_out(rst_out), .clk_en(clk_en), .slot_on(slot_on)
);

// File: tb/sim_clkrst_bank.sv
module sim_clkrst_bank;

   localparam logic [63:0] INV  = 64'h0000_0000_0000_4000;
   localparam logic [63:0] LINK = 64'hFFFF_FFFB_FFFF_FFFE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [63:0] rst_out, clk_en, slot_on;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // model state from the requirements
   logic [63:0] m_rst  = '1;
   logic [63:0] m_stop = ~INV;

   always #10 clk = ~clk;

   clkrst_bank u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rst_out(rst_out), .clk_en(clk_en), .slot_on(slot_on)
   );

   task automatic chk64(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // R2 R3 R4 R9: model update from address map
   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
      case (a)
         12'h040: m_rst[31:0]   = m_rst[31:0]   |  d;
         12'h044: m_rst[31:0]   = m_rst[31:0]   & ~d;
         12'h050: m_rst[63:32]  = m_rst[63:32]  |  d;
         12'h054: m_rst[63:32]  = m_rst[63:32]  & ~d;
         12'h080: m_stop[31:0]  = m_stop[31:0]  |  d;
         12'h084: m_stop[31:0]  = m_stop[31:0]  & ~d;
         12'h090: m_stop[63:32] = m_stop[63:32] |  d;
         12'h094: m_stop[63:32] = m_stop[63:32] & ~d;
         default: ;
      endcase
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #2 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   // R6 R7 R8 output check plus R5 read-back through both aliases
   task automatic check_all(input string req);
      logic [31:0] d;
      logic [63:0] exp_en;
      exp_en = m_stop ^ ~INV;
      chk64(req, "rst_out R6", rst_out, m_rst);
      chk64(req, "clk_en R7", clk_en, exp_en);
      chk64(req, "slot_on R8", slot_on, exp_en & ~(m_rst & LINK));
      bus_rd(12'h040, d); chk64(req, "rd 040 R5", {32'h0, d}, {32'h0, m_rst[31:0]});
      bus_rd(12'h054, d); chk64(req, "rd 054 R5", {32'h0, d}, {32'h0, m_rst[63:32]});
      bus_rd(12'h084, d); chk64(req, "rd 084 R5", {32'h0, d}, {32'h0, m_stop[31:0]});
      bus_rd(12'h090, d); chk64(req, "rd 090 R5", {32'h0, d}, {32'h0, m_stop[63:32]});
      chk64(req, "rst_out after reads R5", rst_out, m_rst);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk64("R1", "rst_out", rst_out, '1);
      chk64("R1", "clk_en", clk_en, '0);
      chk64("R1", "slot_on", slot_on, '0);
      bus_rd(12'h080, d); chk64("R1", "clk word0", {32'h0, d}, 64'hFFFF_BFFF);
      bus_rd(12'h094, d); chk64("R1", "clk word1 alias", {32'h0, d}, 64'hFFFF_FFFF);
      check_all("R1");
   endtask

   task automatic t_release_and_run;
      bus_wr(12'h044, 32'h0000_00F0);   // R4 release resets 4..7
      check_all("R4");
      bus_wr(12'h084, 32'h0000_00F0);   // R7 run clocks 4..7
      check_all("R7");
      bus_wr(12'h040, 32'h0000_0020);   // R3 re-hold slot 5, others kept
      check_all("R3");
      chk64("R8", "slot5 masked by reset", {63'h0, slot_on[5]}, 64'h0);
      chk64("R8", "slot5 clock still runs", {63'h0, clk_en[5]}, 64'h1);
   endtask

   task automatic t_inverted;
      bus_wr(12'h080, 32'h0000_4000);   // R7 set bit 14 runs the clock
      chk64("R7", "slot14 run on set", {63'h0, clk_en[14]}, 64'h1);
      chk64("R8", "slot14 held by reset", {63'h0, slot_on[14]}, 64'h0);
      bus_wr(12'h044, 32'h0000_4000);
      chk64("R8", "slot14 on after release", {63'h0, slot_on[14]}, 64'h1);
      bus_wr(12'h084, 32'h0000_4000);   // R7 clear bit 14 stops it
      chk64("R7", "slot14 stop on clear", {63'h0, clk_en[14]}, 64'h0);
      check_all("R7");
   endtask

   task automatic t_unlinked;
      bus_wr(12'h084, 32'h0000_0001);   // R8 slot 0 has no link
      chk64("R8", "slot0 on in reset", {63'h0, slot_on[0]}, 64'h1);
      bus_wr(12'h094, 32'h0000_0004);   // R2 slot 34 lives in word 1 bit 2
      chk64("R8", "slot34 on in reset", {63'h0, slot_on[34]}, 64'h1);
      bus_wr(12'h094, 32'h0000_0008);   // slot 35 is linked, reset held
      chk64("R8", "slot35 masked", {63'h0, slot_on[35]}, 64'h0);
      check_all("R8");
   endtask

   task automatic t_high_word;
      bus_wr(12'h054, 32'hA5A5_0000);   // R4 clear in upper reset word
      check_all("R2");
      bus_wr(12'h050, 32'h8000_0000);   // R3 set one bit back
      chk64("R2", "slot63 reset", {63'h0, rst_out[63]}, 64'h1);
      check_all("R3");
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      logic [63:0] r0, c0;
      r0 = rst_out; c0 = clk_en;
      bus_wr(12'h048, 32'hFFFF_FFFF);
      bus_wr(12'h060, 32'hFFFF_FFFF);
      bus_wr(12'h000, 32'hFFFF_FFFF);
      bus_wr(12'h098, 32'hFFFF_FFFF);
      chk64("R9", "rst_out unchanged", rst_out, r0);
      chk64("R9", "clk_en unchanged", clk_en, c0);
      bus_rd(12'h048, d); chk64("R9", "unmapped read", {32'h0, d}, 64'h0);
      check_all("R9");
   endtask

   task automatic t_strobe;
      logic [63:0] r0;
      r0 = rst_out;
      @(negedge clk);
      sel = 1'b0; wr = 1'b1; addr = 12'h044; wdata = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      wr = 1'b0;
      chk64("R10", "write without sel", rst_out, r0);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = 12'h044;
      repeat (3) @(negedge clk);
      sel = 1'b0;
      chk64("R10", "held read", rst_out, r0);
      check_all("R10");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_release_and_run();
      t_inverted();
      t_unlinked();
      t_high_word();
      t_unmapped();
      t_strobe();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule